// File: doc/BRIEF.md
# Isochronous IN Endpoint Transmit Buffer

This block stages outbound data for an isochronous IN endpoint of a USB device. Software loads payload bytes one at a time into a 256-byte packet buffer. A 32-bit control/status word lets software shorten a packet, discard the buffer and acknowledge events. It also shows whether the buffer can take a whole new packet. On the bus side, the packet engine asks for data when an IN token arrives and pulls bytes one by one until the block marks the end of the packet.

A packet becomes ready for sending in one of two ways: it fills to the maximum size, or software writes 1 to the short-packet bit. A short packet may hold no bytes at all. Once the last byte leaves, or an empty packet is closed on a token, the block raises a completion flag and an optional interrupt request. The block then accepts new bytes again. If the engine asks for data that is not there, the block records an underrun.

Top module: `iso_in_txfifo`

## Requirements
- R1: After a synchronous reset the status word reads 0x00000001, and `pkt_ready`, `tx_valid`, `tx_end` and `irq` are all 0.
- R2: A byte write is accepted only while no packet is pending. The 256th accepted byte makes the packet pending: `pkt_ready` goes to 1 at the next clock. Byte writes made while a packet is pending change nothing.
- R3: Status bit 0 (room) reads 1 exactly when the buffer holds no bytes and no packet is pending.
- R4: Writing 1 to status bit 7 (short) while no packet is pending makes the current contents pending, even if that is zero bytes. Bit 7 then reads 1 until that packet finishes, and it clears by itself at that point. The same write has no effect while a packet is already pending.
- R5: A pull on a pending packet delivers the next byte, in write order, on `tx_data` with `tx_valid` one cycle after the pull. `tx_end` is high together with the final byte.
- R6: Status bit 1 (done) sets when a packet finishes. Software clears it by writing 1 to bit 1. If a set and a clear arrive in the same cycle, the set wins.
- R7: Status bit 3 (underrun) sets in two cases: a pull arrives while no pending byte is left, or an IN token arrives with no packet pending. Software clears it by writing 1 to bit 3, and a set wins over a clear in the same cycle.
- R8: Writing 1 to status bit 2 (flush) empties the buffer and clears both the pending state and bit 7. In that cycle the flush overrides any byte write, pull or token. Bit 2 always reads 0, and the flush leaves bits 1 and 3 unchanged.
- R9: `irq` is a registered copy of status bit 1 gated by `irq_en`, and it updates on the same clock edge as bit 1.
- R10: Bits 4 to 6 and 8 to 31 always read 0. Writing to those bits, or to bit 0, has no effect.
- R11: An IN token with an empty packet pending gives one cycle with `tx_end` high and `tx_valid` low. The same token finishes the packet and sets bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_en | input | 1 | Enables the interrupt request for packet completion |
| byte_we | input | 1 | Strobe that writes one payload byte into the buffer |
| byte_wdata | input | 8 | Payload byte |
| csr_we | input | 1 | Write strobe for the status word |
| csr_wdata | input | 32 | Write data for the status word (bit 7 sets, bit 2 flushes, bits 1 and 3 clear on 1) |
| csr_rdata | output | 32 | Status word: bit 0 room, bit 1 done, bit 3 underrun, bit 7 short |
| in_token | input | 1 | Pulse from the packet engine for each IN token |
| pull | input | 1 | Packet engine request for the next byte |
| tx_data | output | 8 | Byte delivered to the packet engine |
| tx_valid | output | 1 | `tx_data` holds a new byte |
| tx_end | output | 1 | The packet ends in this cycle |
| pkt_ready | output | 1 | A packet is pending for transmission |
| irq | output | 1 | Completion interrupt request |

## Verification
The buffer state is never shown directly. It comes out through the room bit, `pkt_ready`, and the length and contents of the byte stream delivered on pulls. A wrong count or pointer shows in the cycle after the faulty update in one of three ways: as early or late release, a wrong `tx_end` position, or bytes out of order. A wrong flag latch shows in `csr_rdata` or `irq` on the next clock. The bench compares every output against a queue-based model on every cycle, so a divergence is reported within one cycle of the edge that caused it.

// File: rtl/iso_txfifo_pkg.sv
package iso_txfifo_pkg;
  localparam int CSR_W     = 32;
  localparam int BIT_ROOM  = 0;
  localparam int BIT_DONE  = 1;
  localparam int BIT_FLUSH = 2;
  localparam int BIT_UNDR  = 3;
  localparam int BIT_SHORT = 7;

  typedef struct packed {
    logic flush;
    logic short_set;
    logic done_clr;
    logic undr_clr;
  } csr_cmd_t;
endpackage

// File: rtl/iso_txfifo_ram.sv
module iso_txfifo_ram #(
  parameter int DW    = 8,
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/iso_txfifo_ctrl.sv
module iso_txfifo_ctrl #(
  parameter int MAX_PKT = 256,
  parameter int AW      = $clog2(MAX_PKT)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          byte_we,
  input  logic          flush,
  input  logic          short_set,
  input  logic          pull,
  input  logic          in_token,
  output logic          ram_we,
  output logic [AW-1:0] ram_waddr,
  output logic          ram_re,
  output logic [AW-1:0] ram_raddr,
  output logic          pkt_ready,
  output logic          short_flag,
  output logic          buf_empty,
  output logic          tx_valid,
  output logic          tx_end,
  output logic          done_set,
  output logic          undr_set
);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] LAST_FILL = CW'(MAX_PKT - 1);

  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] fill;
  logic accept, pop, zlp_done, finish, have_byte;

  assign have_byte = pkt_ready && (fill != '0);
  assign accept    = byte_we && !flush && !pkt_ready;
  assign pop       = pull && !flush && have_byte;
  assign zlp_done  = in_token && !pull && !flush && pkt_ready && (fill == '0);
  assign finish    = (pop && fill == CW'(1)) || zlp_done;
  assign undr_set  = !flush && ((pull && !have_byte) || (in_token && !pull && !pkt_ready));
  assign done_set  = finish;
  assign buf_empty = (fill == '0);

  assign ram_we    = accept;
  assign ram_waddr = wptr;
  assign ram_re    = pop;
  assign ram_raddr = rptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0; rptr <= '0; fill <= '0;
      pkt_ready <= 1'b0; short_flag <= 1'b0;
      tx_valid <= 1'b0; tx_end <= 1'b0;
    end else begin
      tx_valid <= pop;
      tx_end   <= finish;
      if (flush) begin
        wptr <= '0; rptr <= '0; fill <= '0;
        pkt_ready <= 1'b0; short_flag <= 1'b0;
      end else begin
        if (accept) wptr <= wptr + 1'b1;
        if (pop)    rptr <= rptr + 1'b1;
        if (accept && !pop)      fill <= fill + 1'b1;
        else if (pop && !accept) fill <= fill - 1'b1;
        if (finish) begin
          pkt_ready  <= 1'b0;
          short_flag <= 1'b0;
        end else if (short_set && !pkt_ready) begin
          pkt_ready  <= 1'b1;
          short_flag <= 1'b1;
        end else if (accept && fill == LAST_FILL) begin
          pkt_ready  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/iso_txfifo_flags.sv
module iso_txfifo_flags (
  input  logic clk,
  input  logic rst,
  input  logic irq_en,
  input  logic done_set,
  input  logic done_clr,
  input  logic undr_set,
  input  logic undr_clr,
  output logic done_flag,
  output logic undr_flag,
  output logic irq
);
  logic done_nxt, undr_nxt;

  always_comb begin
    done_nxt = done_flag;
    if (done_set)      done_nxt = 1'b1;
    else if (done_clr) done_nxt = 1'b0;
    undr_nxt = undr_flag;
    if (undr_set)      undr_nxt = 1'b1;
    else if (undr_clr) undr_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_flag <= 1'b0;
      undr_flag <= 1'b0;
      irq       <= 1'b0;
    end else begin
      done_flag <= done_nxt;
      undr_flag <= undr_nxt;
      irq       <= done_nxt & irq_en;
    end
  end
endmodule

// File: rtl/iso_txfifo_csr.sv
module iso_txfifo_csr
  import iso_txfifo_pkg::*;
(
  input  logic             csr_we,
  input  logic [CSR_W-1:0] csr_wdata,
  input  logic             room,
  input  logic             done_flag,
  input  logic             undr_flag,
  input  logic             short_flag,
  output csr_cmd_t         cmd,
  output logic [CSR_W-1:0] csr_rdata
);
  always_comb begin
    cmd.flush     = csr_we && csr_wdata[BIT_FLUSH];
    cmd.short_set = csr_we && csr_wdata[BIT_SHORT];
    cmd.done_clr  = csr_we && csr_wdata[BIT_DONE];
    cmd.undr_clr  = csr_we && csr_wdata[BIT_UNDR];
  end

  always_comb begin
    csr_rdata            = '0;
    csr_rdata[BIT_ROOM]  = room;
    csr_rdata[BIT_DONE]  = done_flag;
    csr_rdata[BIT_UNDR]  = undr_flag;
    csr_rdata[BIT_SHORT] = short_flag;
  end
endmodule

// File: rtl/iso_in_txfifo.sv
module iso_in_txfifo
  import iso_txfifo_pkg::*;
#(
  parameter int MAX_PKT = 256,
  parameter int DW      = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             irq_en,
  input  logic             byte_we,
  input  logic [DW-1:0]    byte_wdata,
  input  logic             csr_we,
  input  logic [CSR_W-1:0] csr_wdata,
  output logic [CSR_W-1:0] csr_rdata,
  input  logic             in_token,
  input  logic             pull,
  output logic [DW-1:0]    tx_data,
  output logic             tx_valid,
  output logic             tx_end,
  output logic             pkt_ready,
  output logic             irq
);
  localparam int AW = $clog2(MAX_PKT);

  csr_cmd_t      cmd;
  logic          ram_we, ram_re;
  logic [AW-1:0] ram_waddr, ram_raddr;
  logic          short_flag, buf_empty, done_set, undr_set;
  logic          done_flag, undr_flag;

  iso_txfifo_ram #(.DW(DW), .DEPTH(MAX_PKT), .AW(AW)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(byte_wdata),
    .re(ram_re), .raddr(ram_raddr), .rdata(tx_data)
  );

  iso_txfifo_ctrl #(.MAX_PKT(MAX_PKT), .AW(AW)) u_ctrl (
    .clk(clk), .rst(rst), .byte_we(byte_we), .flush(cmd.flush),
    .short_set(cmd.short_set), .pull(pull), .in_token(in_token),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_re(ram_re), .ram_raddr(ram_raddr),
    .pkt_ready(pkt_ready), .short_flag(short_flag), .buf_empty(buf_empty),
    .tx_valid(tx_valid), .tx_end(tx_end), .done_set(done_set), .undr_set(undr_set)
  );

  iso_txfifo_flags u_flags (
    .clk(clk), .rst(rst), .irq_en(irq_en),
    .done_set(done_set), .done_clr(cmd.done_clr),
    .undr_set(undr_set), .undr_clr(cmd.undr_clr),
    .done_flag(done_flag), .undr_flag(undr_flag), .irq(irq)
  );

  iso_txfifo_csr u_csr (
    .csr_we(csr_we), .csr_wdata(csr_wdata),
    .room(buf_empty && !pkt_ready), .done_flag(done_flag),
    .undr_flag(undr_flag), .short_flag(short_flag),
    .cmd(cmd), .csr_rdata(csr_rdata)
  );
endmodule

// File: rtl/iso_in_txfifo_chk.sv
module iso_in_txfifo_chk (
  input logic        clk,
  input logic        rst,
  input logic        csr_we,
  input logic [31:0] csr_wdata,
  input logic [31:0] csr_rdata,
  input logic        pull,
  input logic        tx_valid,
  input logic        tx_end,
  input logic        pkt_ready,
  input logic        irq
);
  assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (csr_rdata[31:8] == '0) && (csr_rdata[6:4] == '0) && !csr_rdata[2]);

  assert_room_excl_R3: assert property (@(posedge clk) disable iff (rst)
    csr_rdata[0] |-> !pkt_ready);

  assert_short_pending_R4: assert property (@(posedge clk) disable iff (rst)
    csr_rdata[7] |-> pkt_ready);

  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (rst)
    (csr_we && csr_wdata[2]) |=> (csr_rdata[0] && !pkt_ready && !csr_rdata[7]));

  assert_end_sets_done_R6: assert property (@(posedge clk) disable iff (rst)
    tx_end |-> csr_rdata[1]);

  assert_dry_pull_R7: assert property (@(posedge clk) disable iff (rst)
    (pull && !pkt_ready && !(csr_we && csr_wdata[2])) |=> csr_rdata[3]);

  assert_irq_follows_done_R9: assert property (@(posedge clk) disable iff (rst)
    irq |-> csr_rdata[1]);

  assert_valid_after_pull_R5: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> $past(pull));
endmodule

bind iso_in_txfifo iso_in_txfifo_chk u_chk (
  .clk(clk), .rst(rst), .csr_we(csr_we), .csr_wdata(csr_wdata),
  .csr_rdata(csr_rdata), .pull(pull), .tx_valid(tx_valid), .tx_end(tx_end),
  .pkt_ready(pkt_ready), .irq(irq)
);

// File: tb/iso_in_txfifo_test.sv
module iso_in_txfifo_test;
  localparam int MAXP = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic irq_en = 1'b0;
  logic byte_we = 1'b0;
  logic [7:0] byte_wdata = '0;
  logic csr_we = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic in_token = 1'b0;
  logic pull = 1'b0;
  logic [31:0] csr_rdata;
  logic [7:0] tx_data;
  logic tx_valid, tx_end, pkt_ready, irq;

  always #2 clk = ~clk;

  iso_in_txfifo uut (
    .clk(clk), .rst(rst), .irq_en(irq_en), .byte_we(byte_we), .byte_wdata(byte_wdata),
    .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .in_token(in_token), .pull(pull), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_end(tx_end), .pkt_ready(pkt_ready), .irq(irq)
  );

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  bit started = 0;

  // reference model state
  byte unsigned q[$];
  bit m_rel, m_short, m_done, m_undr, m_tv, m_te, m_irq;
  logic [7:0] m_td;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      m_rel = 0; m_short = 0; m_done = 0; m_undr = 0;
      m_tv = 0; m_te = 0; m_irq = 0;
    end else begin
      bit fl, o_rel, s_done, s_undr, have;
      fl = csr_we && csr_wdata[2];
      o_rel = m_rel;
      have = m_rel && q.size() > 0;
      s_done = 0; s_undr = 0; m_tv = 0; m_te = 0;
      if (fl) begin
        q.delete(); m_rel = 0; m_short = 0;
      end else begin
        if (pull) begin
          if (have) begin
            m_td = q.pop_front();
            m_tv = 1;
            if (q.size() == 0) begin m_te = 1; s_done = 1; end
          end else s_undr = 1;
        end else if (in_token) begin
          if (!o_rel) s_undr = 1;
          else if (q.size() == 0) begin m_te = 1; s_done = 1; end
        end
        if (byte_we && !o_rel) begin
          q.push_back(byte_wdata);
        end
        if (s_done) begin
          m_rel = 0; m_short = 0;
        end else if (csr_we && csr_wdata[7] && !o_rel) begin
          m_rel = 1; m_short = 1;
        end else if (!o_rel && q.size() == MAXP) begin
          m_rel = 1;
        end
      end
      if (s_done) m_done = 1; else if (csr_we && csr_wdata[1]) m_done = 0;
      if (s_undr) m_undr = 1; else if (csr_we && csr_wdata[3]) m_undr = 0;
      m_irq = m_done && irq_en;
    end
  end

  always @(negedge clk) begin
    if (!rst && started) begin
      chk(tx_valid == m_tv, "R5", "tx_valid", tx_valid, m_tv);
      if (m_tv) chk(tx_data == m_td, "R5", "tx_data", tx_data, m_td);
      chk(tx_end == m_te, "R5", "tx_end", tx_end, m_te);
      chk(pkt_ready == m_rel, "R2", "pkt_ready", pkt_ready, m_rel);
      chk(csr_rdata[0] == (q.size() == 0 && !m_rel), "R3", "room bit",
          csr_rdata[0], (q.size() == 0 && !m_rel));
      chk(csr_rdata[1] == m_done, "R6", "done bit", csr_rdata[1], m_done);
      chk(csr_rdata[3] == m_undr, "R7", "underrun bit", csr_rdata[3], m_undr);
      chk(csr_rdata[7] == m_short, "R4", "short bit", csr_rdata[7], m_short);
      chk({csr_rdata[31:8], csr_rdata[6:4], csr_rdata[2]} == '0, "R10",
          "reserved bits", csr_rdata, 0);
      chk(irq == m_irq, "R9", "irq", irq, m_irq);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 60000) begin
      n_fail++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  task automatic cyc(input bit bwe, input logic [7:0] bd, input bit cwe,
                     input logic [31:0] cd, input bit pl, input bit tk);
    byte_we = bwe; byte_wdata = bd; csr_we = cwe; csr_wdata = cd;
    pull = pl; in_token = tk;
    @(negedge clk);
    byte_we = 0; csr_we = 0; csr_wdata = '0; pull = 0; in_token = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    started = 1;
    // R1 reset state
    chk(csr_rdata == 32'h1, "R1", "status after reset", csr_rdata, 1);
    chk({pkt_ready, tx_valid, tx_end, irq} == 4'b0, "R1", "outputs after reset",
        {pkt_ready, tx_valid, tx_end, irq}, 0);

    // short packet of 10 bytes
    irq_en = 1;
    for (int i = 0; i < 10; i++) cyc(1, 8'(i * 7 + 3), 0, 0, 0, 0);
    cyc(0, 0, 1, 32'h80, 0, 0);
    chk(csr_rdata == 32'h80 && pkt_ready, "R4", "short release", csr_rdata, 32'h80);
    cyc(1, 8'hAA, 0, 0, 0, 0);  // ignored while pending (R2)
    cyc(0, 0, 0, 0, 0, 1);
    chk(tx_valid == 0 && csr_rdata[3] == 0, "R2", "token with data pending", csr_rdata, 32'h80);
    for (int i = 0; i < 10; i++) begin
      cyc(0, 0, 0, 0, 1, 0);
      chk(tx_valid && tx_data == 8'(i * 7 + 3), "R5", "short packet byte", tx_data, i * 7 + 3);
      if (i % 3 == 0) cyc(0, 0, 0, 0, 0, 0);
    end
    chk(csr_rdata == 32'h3 && irq, "R6", "done after short packet", csr_rdata, 3);
    cyc(0, 0, 1, 32'h2, 0, 0);
    chk(csr_rdata == 32'h1 && !irq, "R6", "done cleared by W1C", csr_rdata, 1);

    // full-size packet
    for (int i = 0; i < MAXP; i++) cyc(1, 8'(i ^ 8'h5C), 0, 0, 0, 0);
    chk(pkt_ready && csr_rdata == 32'h0, "R2", "auto release at 256 bytes", csr_rdata, 0);
    cyc(0, 0, 1, 32'h80, 0, 0);
    chk(csr_rdata == 32'h0, "R4", "short write ignored when pending", csr_rdata, 0);
    for (int i = 0; i < MAXP; i++) cyc(0, 0, 0, 0, 1, 0);
    chk(tx_end && csr_rdata == 32'h3, "R5", "end on last byte", csr_rdata, 3);
    cyc(0, 0, 0, 0, 1, 0);
    chk(csr_rdata == 32'hB, "R7", "dry pull underrun", csr_rdata, 32'hB);
    cyc(0, 0, 1, 32'hA, 0, 0);
    chk(csr_rdata == 32'h1, "R7", "underrun cleared", csr_rdata, 1);

    // flush mid-load
    for (int i = 0; i < 50; i++) cyc(1, 8'(i), 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1);
    chk(csr_rdata == 32'h8, "R7", "token without packet", csr_rdata, 8);
    cyc(1, 8'h77, 1, 32'h4, 1, 0);
    chk(csr_rdata == 32'h9 && !pkt_ready && !tx_valid, "R8", "flush empties", csr_rdata, 9);
    cyc(0, 0, 1, 32'h8, 0, 0);
    for (int i = 0; i < 5; i++) cyc(1, 8'(i + 100), 0, 0, 0, 0);
    cyc(0, 0, 1, 32'h80, 0, 0);
    cyc(0, 0, 1, 32'h4, 0, 0);
    chk(csr_rdata == 32'h1 && !pkt_ready, "R8", "flush clears pending short", csr_rdata, 1);

    // zero-length packet, interrupt disabled
    irq_en = 0;
    cyc(0, 0, 1, 32'h80, 0, 0);
    chk(pkt_ready && csr_rdata == 32'h80, "R11", "empty packet pending", csr_rdata, 32'h80);
    cyc(0, 0, 0, 0, 0, 1);
    chk(tx_end && !tx_valid, "R11", "zero-length end", {tx_end, tx_valid}, 2);
    chk(csr_rdata == 32'h3 && !irq, "R9", "irq gated off", {irq, csr_rdata}, 3);

    // set beats clear, reserved writes
    cyc(0, 0, 1, 32'hA, 0, 1);
    chk(csr_rdata == 32'h9, "R7", "set wins over clear", csr_rdata, 9);
    cyc(0, 0, 1, 32'hFFFF_FF71, 0, 0);
    chk(csr_rdata == 32'h9, "R10", "reserved write no effect", csr_rdata, 9);
    irq_en = 1;
    cyc(0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule